// File: doc/BRIEF.md
# Programmable Interrupt Controller Unit

A CPU-side interrupt controller that collects up to 32 interrupt lines and presents one registered request to the core. Each input is resynchronised and then handled in one of two trigger styles, chosen per line at build time. An edge-style line latches a pending bit on each rising edge, and that bit stays set until software clears it. A level-style line has a pending bit that tracks the synchronised input, so the bit clears when the source lowers its line.

Software reaches two registers through a single-cycle register port: an enable mask and the pending status. The request to the core is formed from the mask, the pending bits and the core's global interrupt enable. The request is re-evaluated every cycle, so a mask write or a rise of the global enable takes effect at once. The core takes the request only at an instruction boundary, and that timing is left to the core. A one-cycle wake pulse on every incoming assertion lets the power manager cancel its doze and sleep enables. A sticky flag records assertions that were dropped because their line was already pending. A build option reserves the two lowest lines as non-maskable: with it, the mask resets with those two bits enabled.

Top module: `pic_unit`

## Requirements
- R1: After reset the status register reads 0, and irq_o, wake_o and dropped_o are low.
- R2: After reset the mask register reads 0x00000003 when NMI_EN is 1 and 0 when NMI_EN is 0.
- R3: A rising edge on an edge-style line sets that line's status bit. With the default two synchroniser stages, the bit is set at the third rising clock edge at which the input is sampled high.
- R4: A rising edge on an edge-style line whose status bit is already set, and is not being cleared in the same cycle, leaves the status unchanged and sets dropped_o. dropped_o then stays high until reset.
- R5: irq_o is a register. It is high in a cycle exactly when, in the previous cycle, gie_i was 1 and at least one line had both its mask bit and its status bit set.
- R6: wake_o pulses high for one cycle for each synchronised rising edge on any line, in either style, including dropped assertions. It comes in the same cycle that the status would first show the edge.
- R7: A write with reg_sel_i = 0 loads the mask from reg_wdata_i at the next clock edge.
- R8: A write with reg_sel_i = 1 clears every edge-style status bit whose write-data bit is 1. Bits written 0 are unchanged.
- R9: A level-style status bit equals the synchronised input, delayed by one register. Clear writes have no effect on it.
- R10: When a clear and a new edge hit the same edge-style line in one cycle, the bit ends set and dropped_o is not raised.
- R11: reg_rdata_o returns the mask when reg_sel_i = 0 and the status when reg_sel_i = 1, in the same cycle without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 32 | Interrupt lines from sources (asynchronous) |
| gie_i | input | 1 | Global interrupt enable from the core status register |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 mask, 1 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| irq_o | output | 1 | Registered interrupt request to the core |
| wake_o | output | 1 | One-cycle pulse that clears the doze and sleep enables |
| dropped_o | output | 1 | Sticky flag: an assertion arrived on an already pending line |

## Verification
The hardest case is a software clear that arrives in exactly the cycle in which a new edge reaches the status logic, because the edge is hidden behind the synchroniser and the detection register. To reach it, the stimulus first leaves line 7 pending. It then raises the line again and issues the clear write two clock edges later, when the edge is active in the status logic. A behavioural model checks every cycle that the bit stays set and that dropped_o stays low. Random line activity mixed with mask writes, clear writes and toggles of gie_i covers the request and wake timing.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pic_detect.sv
module pic_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/pic_status.sv
module pic_status #(
  parameter int          W           = 32,
  parameter logic [W-1:0] LEVEL_LINES = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic         wake_o,
  output logic         drop_o
);
  logic [W-1:0] stat_q, stat_d;
  logic         drop_q, wake_q, collide;

  for (genvar i = 0; i < W; i++) begin : g_line
    if (LEVEL_LINES[i]) begin : g_lvl
      assign stat_d[i] = lvl_i[i];
    end else begin : g_edge
      // new edge wins over a clear in the same cycle
      assign stat_d[i] = (stat_q[i] & ~clr_i[i]) | rise_i[i];
    end
  end

  assign collide = |(rise_i & stat_q & ~clr_i & ~LEVEL_LINES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      drop_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      drop_q <= drop_q | collide;
      wake_q <= |rise_i;
    end
  end

  assign stat_o = stat_q;
  assign wake_o = wake_q;
  assign drop_o = drop_q;

  AST_DROP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q |=> drop_q); // R4
  AST_LEVEL_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & LEVEL_LINES) == ($past(lvl_i) & LEVEL_LINES))); // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rise_i & clr_i & ~LEVEL_LINES) |=> ((stat_q & $past(rise_i & clr_i & ~LEVEL_LINES)) == $past(rise_i & clr_i & ~LEVEL_LINES))); // R10
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter int           NUM_LINES   = 32,
  parameter int           SYNC_STAGES = 2,
  parameter bit           NMI_EN      = 1'b1,
  parameter logic [NUM_LINES-1:0] LEVEL_LINES = 32'h0000_F000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 gie_i,
  input  logic                 reg_we_i,
  input  logic                 reg_sel_i,
  input  logic [NUM_LINES-1:0] reg_wdata_i,
  output logic [NUM_LINES-1:0] reg_rdata_o,
  output logic                 irq_o,
  output logic                 wake_o,
  output logic                 dropped_o
);
  localparam logic [NUM_LINES-1:0] MASK_RST =
    NMI_EN ? {{(NUM_LINES-2){1'b0}}, 2'b11} : '0;

  logic [NUM_LINES-1:0] sync_lvl, rise, clr, stat, mask_q;
  logic                 irq_q;
  reg_sel_e             sel;

  assign sel = reg_sel_e'(reg_sel_i);

  pic_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(sync_lvl));

  pic_detect #(.W(NUM_LINES)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_lvl), .rise_o(rise));

  assign clr = (reg_we_i && sel == SEL_STAT) ? reg_wdata_i : '0;

  pic_status #(.W(NUM_LINES), .LEVEL_LINES(LEVEL_LINES)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_lvl), .rise_i(rise),
    .clr_i(clr), .stat_o(stat), .wake_o(wake_o), .drop_o(dropped_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_RST;
      irq_q  <= 1'b0;
    end else begin
      if (reg_we_i && sel == SEL_MASK) mask_q <= reg_wdata_i;
      irq_q <= gie_i & |(mask_q & stat);
    end
  end

  assign irq_o       = irq_q;
  assign reg_rdata_o = (sel == SEL_MASK) ? mask_q : stat;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |=> !irq_o); // R5
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_sel_i) |=> (mask_q == $past(reg_wdata_i))); // R7
  AST_WAKE_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((|(stat & ~$past(stat))) -> wake_o)); // R6
endmodule

// File: tb/pic_unit_test.sv
module pic_unit_test;
  localparam int N = 32;
  localparam logic [N-1:0] LVL = 32'h0000_F000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] line = '0, wdata = '0, rdata;
  logic gie = 1'b0, we = 1'b0, sel = 1'b0;
  logic irq, wake, dropped;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  pic_unit #(.NUM_LINES(N), .SYNC_STAGES(2), .NMI_EN(1'b1), .LEVEL_LINES(LVL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .gie_i(gie), .reg_we_i(we),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .wake_o(wake), .dropped_o(dropped));

  // behavioural reference model
  logic [N-1:0] m_s1, m_s2, m_prev, m_stat, m_mask;
  logic m_irq, m_wake, m_drop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
      m_mask = 32'h3; m_irq = 0; m_wake = 0; m_drop = 0;
    end else begin
      logic [N-1:0] ev, clrv, nstat;
      ev    = m_s2 & ~m_prev;
      clrv  = (we && sel) ? wdata : '0;
      m_irq = gie && ((m_mask & m_stat) != 0);
      for (int i = 0; i < N; i++)
        nstat[i] = LVL[i] ? m_s2[i] : ((m_stat[i] & ~clrv[i]) | ev[i]);
      m_drop = m_drop | ((ev & m_stat & ~clrv & ~LVL) != 0);
      m_wake = (ev != 0);
      m_stat = nstat;
      if (we && !sel) m_mask = wdata;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = line;
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  bit model_on = 0;
  always @(negedge clk) begin
    #5;
    if (model_on && rst_n) begin
      chk("R5 irq", irq, m_irq);
      chk("R6 wake", wake, m_wake);
      chk("R4 dropped", dropped, m_drop);
      chk("R11 rdata", rdata, sel ? m_stat : m_mask);
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [N-1:0] d);
    sel = s; we = 1'b1; wdata = d;
    step(1);
    we = 1'b0; wdata = '0;
  endtask

  task automatic settle;  // sample point inside the current low phase
    #5;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    settle();
    sel = 1'b1; #1;
    chk("R1 status reset", rdata, '0);
    chk("R1 irq reset", {31'b0, irq}, '0);
    chk("R1 dropped/wake reset", {30'b0, dropped, wake}, '0);
    sel = 1'b0; #1;
    chk("R2 mask reset", rdata, 32'h3);
    @(negedge clk);
    rst_n = 1'b1;
    model_on = 1;
    step(2);

    // R3/R5/R6: edge line 0 with gie set
    gie = 1'b1;
    line[0] = 1'b1;
    step(3); settle(); sel = 1'b1; #1;
    chk("R3 line0 pending", rdata & 32'h1, 32'h1);
    step(1); settle();
    chk("R5 irq from line0", {31'b0, irq}, 32'h1);
    line[0] = 1'b0;
    step(1);
    wr(1'b1, 32'h1);                 // R8 clear
    step(1); settle(); sel = 1'b1; #1;
    chk("R8 line0 cleared", rdata & 32'h1, '0);

    // R7: line 5 masked, then unmask
    line[5] = 1'b1; step(1); line[5] = 1'b0;
    step(4); settle();
    chk("R5 masked line no irq", {31'b0, irq}, '0);
    wr(1'b0, 32'h23);
    step(1); settle(); sel = 1'b0; #1;
    chk("R7 mask loaded", rdata, 32'h23);
    chk("R5 irq after mask write", {31'b0, irq}, 32'h1);
    gie = 1'b0; step(2); settle();
    chk("R5 irq off without gie", {31'b0, irq}, '0);
    gie = 1'b1;

    // R10: line 7 pending, new edge collides with clear
    line[7] = 1'b1; step(1); line[7] = 1'b0; step(4);
    line[7] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    sel = 1'b1; we = 1'b1; wdata = 32'h80;
    step(1); we = 1'b0; wdata = '0;
    settle(); sel = 1'b1; #1;
    chk("R10 set wins", rdata & 32'h80, 32'h80);
    chk("R10 no drop", {31'b0, dropped}, '0);
    line[7] = 1'b0;

    // R4: repeated edge on pending line 5
    step(2); line[5] = 1'b1; step(1); line[5] = 1'b0;
    step(4); settle();
    chk("R4 dropped set", {31'b0, dropped}, 32'h1);
    wr(1'b1, 32'hA0); step(3); settle();
    chk("R4 dropped sticky", {31'b0, dropped}, 32'h1);

    // R9: level line 13
    line[13] = 1'b1; step(4);
    wr(1'b1, 32'h2000); settle(); sel = 1'b1; #1;
    chk("R9 level ignores clear", rdata & 32'h2000, 32'h2000);
    line[13] = 1'b0; step(4); settle(); sel = 1'b1; #1;
    chk("R9 level follows input", rdata & 32'h2000, '0);

    // random traffic checked by model
    for (int r = 0; r < 400; r++) begin
      line = $urandom() & $urandom() & $urandom();
      gie  = ($urandom() % 4) != 0;
      sel  = $urandom() % 2;
      case ($urandom() % 6)
        0: begin we = 1'b1; wdata = $urandom(); end
        default: begin we = 1'b0; wdata = '0; end
      endcase
      step(1);
    end
    we = 1'b0;
    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule